// File: doc/BRIEF.md
# Framed Serial Readback Controller

This block streams a stored configuration image out as a single serial bit stream, one frame at a time. A rising edge on the trigger input, sampled while the block is idle, starts a readback. The controller first spends six clocks staging frame 0, then sends every frame as one start bit followed by the frame payload, most significant bit first. The readback-active flag is High for the whole readback. The frame contents come from an external parallel source. The controller asks that source for one slice of a frame per clock, and it asks only during the six clocks that come before each start bit. The slices are collected in a staging register. The whole frame is copied into the output shifter on the clock edge that begins its start bit, so the shifter only shifts while a frame is being sent.

A readback can be cut short when the abort option is enabled: a falling edge of the trigger while a readback is active stops it. The controller then spends one clock per frame re-initialising and ignores the trigger in that time. A clock-select input chooses whether the configuration clock or an alternate user clock drives the whole block. If the trigger stays Low, the block stays idle and its serial output stays at the idle level.

Top module: `rbk_serializer`

## Requirements
- R1: After a synchronous reset the active flag is 0, the serial output is 1 (idle level) and no slice request is made.
- R2: A 0-to-1 change of the trigger between two rising clock edges, seen while idle, starts a readback. The active flag is 1 from the cycle after that edge until the final payload bit of the last frame has been sent.
- R3: The first six cycles of a readback are a staging lead-in. In these cycles the serial output stays 1 and slices 0 to 5 of frame 0 are requested, one per cycle in ascending order. The first start bit follows at once.
- R4: Each frame is sent as one start bit of value 0, then FRAME_BITS payload bits, MSB first, with no gap between frames.
- R5: A frame's payload is made by joining its six slices in order, slice 0 in the most significant position, and keeping the top FRAME_BITS bits. FRAME_BITS must be at least 6.
- R6: In every frame except the last, the next frame's slices 0 to 5 are requested during the frame's final six payload cycles. At all other times during a frame, no request is made.
- R7: A new rising trigger edge during an active readback is ignored, and the readback continues unchanged.
- R8: With abort enabled, a 1-to-0 change of the trigger during an active readback ends it at that clock edge. From the next cycle the active flag is 0 and the output is 1.
- R9: After an abort the block re-initialises for NUM_FRAMES cycles and ignores trigger edges in that time. After that it accepts a new rising edge.
- R10: With abort disabled, a falling trigger edge during a readback has no effect.
- R11: With the clock-select input at 1, the alternate clock drives all sequencing and the configuration clock has no effect. With it at 0, the configuration clock drives the block.
- R12: While the trigger is held at 0, the block stays idle with its output at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock, the default readback clock |
| alt_clk | input | 1 | Alternate user readback clock |
| clk_sel | input | 1 | 1 selects alt_clk, 0 selects cfg_clk |
| rst | input | 1 | Synchronous active-high reset, in the selected clock domain |
| trig | input | 1 | Readback trigger: a rising edge starts, a falling edge may abort |
| abort_en | input | 1 | Enables abort on a falling trigger edge |
| src_req | output | 1 | Slice request to the frame source |
| src_frame | output | FRM_W | Frame index of the requested slice |
| src_slice | output | 3 | Slice index 0 to 5 within the frame |
| src_data | input | SLICE_W | Slice returned by the frame source in the same cycle |
| rb_dout | output | 1 | Serial readback data |
| rb_busy | output | 1 | Readback-active flag |

## Verification
The trigger is sampled at a rising edge of the selected clock, and the lead-in state starts at that edge. So the active flag, the first lead-in request and the idle-level output are all due in the very next cycle. Each later bit follows exactly one clock after the one before it: six lead-in cycles, then one start bit and FRAME_BITS payload bits per frame. An abort takes effect one cycle after the falling edge is sampled, and idle returns NUM_FRAMES cycles later. The bench's model advances on the same selected clock edge and the bench compares on the opposite edge, so each expected value is compared in the cycle it is due.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    // Number of clocks used to stage a frame before its start bit
    localparam int LOAD_WIN  = 6;
    localparam logic START_LVL = 1'b0;
    localparam logic IDLE_LVL  = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_FRAME  = 2'd2,
        ST_REINIT = 2'd3
    } rbk_state_e;

    // Control bundle from sequencer to datapath
    typedef struct packed {
        logic busy;   // readback active
        logic fetch;  // slice request this cycle
        logic xfer;   // copy staged frame into shifter at this edge
        logic shift;  // payload bit on the output, shift at this edge
        logic start;  // start bit on the output
    } rbk_ctl_t;

    function automatic int slice_width(int frame_bits);
        return (frame_bits + LOAD_WIN - 1) / LOAD_WIN;
    endfunction

    function automatic int frm_width(int num_frames);
        return (num_frames > 1) ? $clog2(num_frames) : 1;
    endfunction

endpackage

// File: rtl/rbk_clk_sel.sv
module rbk_clk_sel (
    input  logic cfg_clk,
    input  logic alt_clk,
    input  logic sel,
    output logic rb_clk
);
    // Plain selection; glitch-free switching is left to the integrator
    assign rb_clk = sel ? alt_clk : cfg_clk;
endmodule

// File: rtl/rbk_seq.sv
module rbk_seq
    import rbk_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int NUM_FRAMES = 4,
    localparam int FRM_W = frm_width(NUM_FRAMES),
    localparam int POS_W = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             abort_en,
    output rbk_ctl_t         ctl,
    output logic [FRM_W-1:0] fetch_frame,
    output logic [2:0]       fetch_slice
);
    localparam logic [POS_W-1:0] LAST_LEAD = POS_W'(LOAD_WIN - 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS);
    localparam logic [POS_W-1:0] WIN_FIRST = POS_W'(FRAME_BITS - LOAD_WIN + 1);
    localparam logic [FRM_W-1:0] LAST_FRM  = FRM_W'(NUM_FRAMES - 1);

    rbk_state_e       state;
    logic [POS_W-1:0] pos;   // lead-in count, or bit position in frame
    logic [FRM_W-1:0] frm;   // frame index, or re-init count
    logic             trig_q;
    logic             trig_rise, trig_fall, abort_hit, last_frame, in_win;

    assign trig_rise  = trig & ~trig_q;
    assign trig_fall  = ~trig & trig_q;
    assign last_frame = (frm == LAST_FRM);
    assign in_win     = (state == ST_FRAME) && (pos >= WIN_FIRST) && !last_frame;

    always_comb begin
        ctl.busy  = (state == ST_LEAD) || (state == ST_FRAME);
        ctl.fetch = (state == ST_LEAD) || in_win;
        ctl.xfer  = ((state == ST_LEAD) && (pos == LAST_LEAD)) ||
                    ((state == ST_FRAME) && (pos == LAST_POS) && !last_frame);
        ctl.shift = (state == ST_FRAME) && (pos != '0);
        ctl.start = (state == ST_FRAME) && (pos == '0);
        if (state == ST_LEAD) begin
            fetch_frame = '0;
            fetch_slice = 3'(pos);
        end else begin
            fetch_frame = frm + FRM_W'(1);
            fetch_slice = 3'(pos - WIN_FIRST);
        end
    end

    assign abort_hit = ctl.busy && abort_en && trig_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pos    <= '0;
            frm    <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= trig;
            if (abort_hit) begin
                state <= ST_REINIT;
                frm   <= '0;
                pos   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: if (trig_rise) begin
                        state <= ST_LEAD;
                        pos   <= '0;
                    end
                    ST_LEAD: if (pos == LAST_LEAD) begin
                        state <= ST_FRAME;
                        pos   <= '0;
                        frm   <= '0;
                    end else begin
                        pos <= pos + POS_W'(1);
                    end
                    ST_FRAME: if (pos == LAST_POS) begin
                        pos <= '0;
                        if (last_frame) begin
                            state <= ST_IDLE;
                            frm   <= '0;
                        end else begin
                            frm <= frm + FRM_W'(1);
                        end
                    end else begin
                        pos <= pos + POS_W'(1);
                    end
                    ST_REINIT: if (last_frame) begin
                        state <= ST_IDLE;
                        frm   <= '0;
                    end else begin
                        frm <= frm + FRM_W'(1);
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Guards
    assert_start_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && trig_rise) |=> (state == ST_LEAD && pos == '0));

    assert_lead_len_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEAD && pos == LAST_LEAD && !abort_hit)
        |=> (state == ST_FRAME && pos == '0 && frm == '0));

    assert_busy_rise_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && trig_rise) |=> !(state == ST_LEAD && pos == '0));

    assert_abort_enters_reinit_R8: assert property (@(posedge clk) disable iff (rst)
        abort_hit |=> (state == ST_REINIT && frm == '0));

    assert_reinit_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REINIT && !last_frame) |=> (state == ST_REINIT));

    assert_no_abort_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl.busy && !abort_en) |=> (state != ST_REINIT));
endmodule

// File: rtl/rbk_shift.sv
module rbk_shift
    import rbk_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    localparam int SLICE_W = slice_width(FRAME_BITS),
    localparam int PAD_W   = SLICE_W * LOAD_WIN
) (
    input  logic               clk,
    input  logic               rst,
    input  rbk_ctl_t           ctl,
    input  logic [2:0]         slice_idx,
    input  logic [SLICE_W-1:0] slice_data,
    output logic               dout
);
    logic [PAD_W-1:0]      stage_q, stage_nxt;
    logic [FRAME_BITS-1:0] shreg_q;

    // Each slice lane of the staging register takes the source word when addressed
    for (genvar gk = 0; gk < LOAD_WIN; gk++) begin : g_lane
        localparam int HI = PAD_W - 1 - gk * SLICE_W;
        assign stage_nxt[HI -: SLICE_W] =
            (ctl.fetch && slice_idx == 3'(gk)) ? slice_data : stage_q[HI -: SLICE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            shreg_q <= '0;
        end else begin
            stage_q <= stage_nxt;
            if (ctl.xfer)
                shreg_q <= stage_nxt[PAD_W-1 -: FRAME_BITS];
            else if (ctl.shift)
                shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_comb begin
        if (ctl.shift)      dout = shreg_q[FRAME_BITS-1];
        else if (ctl.start) dout = START_LVL;
        else                dout = IDLE_LVL;
    end

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (rst)
        !ctl.busy |-> (dout == IDLE_LVL));

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !ctl.busy |-> !ctl.fetch);
endmodule

// File: rtl/rbk_serializer.sv
module rbk_serializer
    import rbk_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int NUM_FRAMES = 4,
    localparam int FRM_W   = frm_width(NUM_FRAMES),
    localparam int SLICE_W = slice_width(FRAME_BITS)
) (
    input  logic               cfg_clk,
    input  logic               alt_clk,
    input  logic               clk_sel,
    input  logic               rst,
    input  logic               trig,
    input  logic               abort_en,
    output logic               src_req,
    output logic [FRM_W-1:0]   src_frame,
    output logic [2:0]         src_slice,
    input  logic [SLICE_W-1:0] src_data,
    output logic               rb_dout,
    output logic               rb_busy
);
    logic     rb_clk;
    rbk_ctl_t ctl;

    rbk_clk_sel u_clk (
        .cfg_clk (cfg_clk),
        .alt_clk (alt_clk),
        .sel     (clk_sel),
        .rb_clk  (rb_clk)
    );

    rbk_seq #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) u_seq (
        .clk         (rb_clk),
        .rst         (rst),
        .trig        (trig),
        .abort_en    (abort_en),
        .ctl         (ctl),
        .fetch_frame (src_frame),
        .fetch_slice (src_slice)
    );

    rbk_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk        (rb_clk),
        .rst        (rst),
        .ctl        (ctl),
        .slice_idx  (src_slice),
        .slice_data (src_data),
        .dout       (rb_dout)
    );

    assign src_req = ctl.fetch;
    assign rb_busy = ctl.busy;

    assert_slice_in_range_R6: assert property (@(posedge rb_clk) disable iff (rst)
        src_req |-> (src_slice < 3'(LOAD_WIN)));
endmodule

// File: tb/rbk_serializer_tb.sv
module rbk_serializer_tb;
    localparam int FB      = 16;
    localparam int NF      = 4;
    localparam int WIN     = 6;
    localparam int SLICE_W = (FB + WIN - 1) / WIN;
    localparam int PAD_W   = SLICE_W * WIN;
    localparam int FRM_W   = (NF > 1) ? $clog2(NF) : 1;

    logic cfg_clk = 1'b0, alt_clk = 1'b0;
    logic clk_sel = 1'b0, rst = 1'b1, trig = 1'b0, abort_en = 1'b0;
    logic src_req, rb_dout, rb_busy;
    logic [FRM_W-1:0]   src_frame;
    logic [2:0]         src_slice;
    logic [SLICE_W-1:0] src_data;
    logic rbk;
    int   seed = 1;

    always #5 cfg_clk = ~cfg_clk;   // 100 MHz
    always #7 alt_clk = ~alt_clk;
    assign rbk = clk_sel ? alt_clk : cfg_clk;   // R11: readback clock choice

    function automatic logic [SLICE_W-1:0] src_fn(int f, int s, int sd);
        int v;
        v = (f * 73 + s * 29 + sd * 13) ^ (sd >> s) ^ (f << 1);
        return SLICE_W'(v);
    endfunction

    assign src_data = src_fn(int'(src_frame), int'(src_slice), seed);

    rbk_serializer #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) u_dut (
        .cfg_clk(cfg_clk), .alt_clk(alt_clk), .clk_sel(clk_sel), .rst(rst),
        .trig(trig), .abort_en(abort_en), .src_req(src_req), .src_frame(src_frame),
        .src_slice(src_slice), .src_data(src_data), .rb_dout(rb_dout), .rb_busy(rb_busy)
    );

    // Behavioural reference: queues of per-cycle expected output and request
    bit exp_q[$];
    bit req_q[$];
    int reinit_left = 0;
    bit trig_prev = 0;
    int checks = 0, failures = 0;
    bit chk_on = 0;
    string cur = "R1";

    function automatic void build();
        logic [PAD_W-1:0] pad;
        for (int i = 0; i < WIN; i++) begin exp_q.push_back(1'b1); req_q.push_back(1'b1); end
        for (int f = 0; f < NF; f++) begin
            for (int s = 0; s < WIN; s++) pad[PAD_W-1-s*SLICE_W -: SLICE_W] = src_fn(f, s, seed);
            exp_q.push_back(1'b0); req_q.push_back(1'b0);
            for (int p = 1; p <= FB; p++) begin
                exp_q.push_back(pad[PAD_W-1-(p-1)]);
                req_q.push_back((f < NF - 1) && (p >= FB - WIN + 1));
            end
        end
    endfunction

    always @(posedge rbk) begin
        if (rst) begin
            exp_q.delete(); req_q.delete(); reinit_left = 0; trig_prev = 0;
        end else begin
            if (exp_q.size() > 0) begin
                if (abort_en && !trig && trig_prev) begin
                    exp_q.delete(); req_q.delete(); reinit_left = NF;
                end else begin
                    void'(exp_q.pop_front()); void'(req_q.pop_front());
                end
            end else if (reinit_left > 0) begin
                reinit_left--;
            end else if (trig && !trig_prev) begin
                build();
            end
            trig_prev = trig;
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", cur, what, act, exp, $time);
        end
    endtask

    always @(negedge rbk) begin
        if (chk_on) begin
            chk("rb_dout", rb_dout, exp_q.size() > 0 ? exp_q[0] : 1'b1);
            chk("rb_busy", rb_busy, exp_q.size() > 0);
            chk("src_req", src_req, exp_q.size() > 0 ? req_q[0] : 1'b0);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge rbk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge cfg_clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        // R1: reset state
        step(3);
        chk_on = 1;
        step(2);
        rst = 1'b0;
        step(5);
        // R12: trigger held low keeps the block idle
        cur = "R12";
        step(20);
        // R2, R3, R4, R5, R6: full readback on the default clock
        cur = "R2"; trig = 1'b1; step(1);
        cur = "R3"; step(6);
        cur = "R4"; step(30);
        cur = "R5"; step(20);
        cur = "R6"; step(30);
        trig = 1'b0; step(3);
        // R10: falling edge ignored with abort off; R7: rising edge ignored while busy
        seed = 7;
        cur = "R2"; trig = 1'b1; step(20);
        cur = "R10"; trig = 1'b0; step(5);
        cur = "R7"; trig = 1'b1; step(60);
        trig = 1'b0; step(3);
        // R8: abort mid-frame, R9: re-init ignores triggers, then restart
        seed = 22; abort_en = 1'b1;
        cur = "R8"; trig = 1'b1; step(30);
        trig = 1'b0; step(1);
        cur = "R9"; trig = 1'b1; step(6);
        trig = 1'b0; step(2);
        trig = 1'b1; step(80);
        trig = 1'b0; step(3);
        // R8: abort inside the lead-in
        cur = "R8"; trig = 1'b1; step(3);
        trig = 1'b0; step(8);
        // R11: alternate clock drives the block
        rst = 1'b1; clk_sel = 1'b1; abort_en = 1'b0; seed = 41;
        step(3);
        rst = 1'b0;
        cur = "R11"; step(2);
        trig = 1'b1; step(80);
        trig = 1'b0; step(4);
        report();
    end
endmodule